// File: doc/BRIEF.md
# Masked Level Interrupt Controller

This block gathers sixteen level-sensitive interrupt request lines into one interrupt output for a processor. Each line passes through a short synchronizer and then sets or clears its own bit in a source register. The source bit simply tracks the line's level. An enable mask, reached through a 16-bit register port, selects which source bits may raise the combined output.

Software learns which line to service by reading the vector register. It returns a small code for the lowest-numbered line that is both asserted and enabled, or zero when no enabled line is asserted. The register port accepts byte, halfword and word accesses. A byte write is merged into the addressed halfword. A word access is split into the halfword at the given address and the halfword two bytes above it.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: Each source bit takes the level of its `irq_in` line. A change on the line becomes visible in the source register, and so in `irq_out` and the vector, after SYNC_STAGES+1 rising clock edges (3 edges by default). It is not visible after fewer edges.
- R2: `irq_out` is high exactly when (source AND mask) is nonzero. It depends only on registers, so a mask write changes `irq_out` directly after the edge that performs the write.
- R3: A read is a cycle with `bus_valid`=1 and `bus_write`=0. Its data appears on `bus_rdata` with `bus_rvalid`=1 after the next rising edge. `bus_rvalid` is 0 after any cycle without a read.
- R4: A halfword read (`bus_size`=1) at offset 0x000 returns (i+1)*4 for the lowest set bit i of (source AND mask). It returns 0 when no such bit is set. Bits 31:16 of the read data are 0.
- R5: Offset 0x002 holds the 16-bit enable mask. A halfword write there replaces it with `bus_wdata[15:0]`, and a halfword read returns it.
- R6: After reset the mask is 0x0010, the source register is 0, `irq_out` is 0 and `bus_rvalid` is 0.
- R7: In a byte access (`bus_size`=0), `bus_addr[0]` selects the lane: 0 selects bits 7:0 of the halfword at the address with bit 0 cleared, and 1 selects bits 15:8. A byte read returns that lane in `bus_rdata[7:0]` with the upper bits 0. A byte write of `bus_wdata[7:0]` at 0x002 or 0x003 replaces only that byte of the mask.
- R8: In a word access (`bus_size`=2), the halfword at `bus_addr` maps to data bits 15:0 and the halfword at `bus_addr`+2 maps to data bits 31:16, for both reads and writes.
- R9: When several enabled lines are asserted, the vector names the lowest-numbered one.
- R10: Writes to any offset other than the mask have no effect, and this includes offset 0x000. A halfword access at an odd address, and any access with `bus_size`=3, decodes nothing. Reads of undecoded offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 16 | Level interrupt request lines, one per source |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| bus_addr | input | ADDR_W (12) | Byte offset of the access |
| bus_wdata | input | 32 | Write data, with lanes aligned as in R7 and R8 |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read |
| irq_out | output | 1 | Combined interrupt, high while any enabled source is set |

## Verification
A single line is raised and lowered, and `irq_out` is sampled around the third edge. This separates a correct synchronizer depth from one that is too short or too long. Line patterns with several bits set are combined with masks that hide the low bits one after another, so the vector must move to the next enabled line; this catches inverted priority, raw-bitmap reads and an ungated source. Byte, halfword and word accesses at both halfword offsets, plus writes to the vector offset, odd addresses and the reserved size, confirm that each write reaches only the intended lane and that each read lands in the correct data bits.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  localparam int IRQ_LINES = 16;
  localparam int HALF_W    = 16;
  localparam int WORD_W    = 2 * HALF_W;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  // Lowest set index i gives (i+1)*4; no bit set gives zero.
  function automatic logic [HALF_W-1:0] encode_vector(input logic [IRQ_LINES-1:0] pend);
    logic [HALF_W-1:0] v;
    v = '0;
    for (int i = IRQ_LINES - 1; i >= 0; i--) begin
      if (pend[i]) v = HALF_W'((i + 1) << 2);
    end
    return v;
  endfunction

  // Replace one byte lane of a halfword.
  function automatic logic [HALF_W-1:0] merge_byte(input logic [HALF_W-1:0] old,
                                                   input logic lane,
                                                   input logic [7:0] b);
    return lane ? {b, old[7:0]} : {old[HALF_W-1:8], b};
  endfunction

  // Pick one byte lane of a halfword, zero-extended.
  function automatic logic [WORD_W-1:0] pick_byte(input logic [HALF_W-1:0] hw,
                                                  input logic lane);
    return WORD_W'(lane ? hw[HALF_W-1:8] : hw[7:0]);
  endfunction
endpackage

// File: rtl/irq_level_sync.sv
module irq_level_sync
  import lvl_irq_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IRQ_LINES-1:0] lvl_in,
  output logic [IRQ_LINES-1:0] src_q
);
  logic [IRQ_LINES-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= '0;
      src_q <= '0;
    end else begin
      stage[0] <= lvl_in;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
      src_q <= stage[STAGES-1];
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import lvl_irq_pkg::*;
#(
  parameter int                ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] MASK_OFF   = ADDR_W'(2),
  parameter logic [HALF_W-1:0] MASK_RESET = 16'h0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  acc_size_e         size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [HALF_W-1:0] mask_q,
  output logic              mask_wr
);
  localparam logic [ADDR_W-1:0] HALF_STEP = ADDR_W'(2);

  logic [HALF_W-1:0] mask_nxt;
  logic              hit;
  logic [ADDR_W-1:0] hw_base;
  logic [ADDR_W-1:0] hi_addr;

  assign hw_base = {addr[ADDR_W-1:1], 1'b0};
  assign hi_addr = addr + HALF_STEP;

  always_comb begin
    mask_nxt = mask_q;
    hit      = 1'b0;
    unique case (size)
      SZ_HALF: if (addr == MASK_OFF) begin
        mask_nxt = wdata[HALF_W-1:0];
        hit      = 1'b1;
      end
      SZ_BYTE: if (hw_base == MASK_OFF) begin
        mask_nxt = merge_byte(mask_q, addr[0], wdata[7:0]);
        hit      = 1'b1;
      end
      SZ_WORD: begin
        if (addr == MASK_OFF) begin
          mask_nxt = wdata[HALF_W-1:0];
          hit      = 1'b1;
        end else if (hi_addr == MASK_OFF) begin
          mask_nxt = wdata[WORD_W-1:HALF_W];
          hit      = 1'b1;
        end
      end
      default: ;
    endcase
  end

  assign mask_wr = wr_en && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= MASK_RESET;
    else if (mask_wr) mask_q <= mask_nxt;
  end
endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
  import lvl_irq_pkg::*;
#(
  parameter int                ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] VEC_OFF  = ADDR_W'(0),
  parameter logic [ADDR_W-1:0] MASK_OFF = ADDR_W'(2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  acc_size_e         size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [HALF_W-1:0] vec,
  input  logic [HALF_W-1:0] mask,
  output logic [WORD_W-1:0] rdata,
  output logic              rvalid
);
  localparam logic [ADDR_W-1:0] HALF_STEP = ADDR_W'(2);

  function automatic logic [HALF_W-1:0] hw_at(input logic [ADDR_W-1:0] a,
                                              input logic [HALF_W-1:0] v,
                                              input logic [HALF_W-1:0] m);
    if (a == VEC_OFF)  return v;
    if (a == MASK_OFF) return m;
    return '0;
  endfunction

  logic [WORD_W-1:0] rd_nxt;

  always_comb begin
    unique case (size)
      SZ_BYTE: rd_nxt = pick_byte(hw_at({addr[ADDR_W-1:1], 1'b0}, vec, mask), addr[0]);
      SZ_HALF: rd_nxt = WORD_W'(hw_at(addr, vec, mask));
      SZ_WORD: rd_nxt = {hw_at(addr + HALF_STEP, vec, mask), hw_at(addr, vec, mask)};
      default: rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_nxt;
    end
  end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lvl_irq_pkg::*;
#(
  parameter int                ADDR_W      = 12,
  parameter int                SYNC_STAGES = 2,
  parameter logic [HALF_W-1:0] MASK_RESET  = 16'h0010,
  parameter logic [ADDR_W-1:0] VEC_OFF     = ADDR_W'(0),
  parameter logic [ADDR_W-1:0] MASK_OFF    = ADDR_W'(2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IRQ_LINES-1:0] irq_in,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [1:0]           bus_size,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic [WORD_W-1:0]    bus_rdata,
  output logic                 bus_rvalid,
  output logic                 irq_out
);
  // Named internal events for the checker.
  logic [IRQ_LINES-1:0] src_q;
  logic [HALF_W-1:0]    mask_q;
  logic [IRQ_LINES-1:0] pend;
  logic [HALF_W-1:0]    vec;
  logic                 mask_wr;
  logic                 rd_en;
  logic                 wr_en;
  acc_size_e            size;

  assign size  = acc_size_e'(bus_size);
  assign rd_en = bus_valid && !bus_write;
  assign wr_en = bus_valid && bus_write;

  irq_level_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .lvl_in(irq_in), .src_q(src_q)
  );

  irq_mask_reg #(.ADDR_W(ADDR_W), .MASK_OFF(MASK_OFF), .MASK_RESET(MASK_RESET)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .size(size), .addr(bus_addr),
    .wdata(bus_wdata), .mask_q(mask_q), .mask_wr(mask_wr)
  );

  assign pend    = src_q & mask_q[IRQ_LINES-1:0];
  assign vec     = encode_vector(pend);
  assign irq_out = |pend;

  irq_read_port #(.ADDR_W(ADDR_W), .VEC_OFF(VEC_OFF), .MASK_OFF(MASK_OFF)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .size(size), .addr(bus_addr),
    .vec(vec), .mask(mask_q), .rdata(bus_rdata), .rvalid(bus_rvalid)
  );
endmodule

// File: rtl/lvl_irq_ctrl_chk.sv
module lvl_irq_ctrl_chk
  import lvl_irq_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [HALF_W-1:0] MASK_RESET  = 16'h0010
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [IRQ_LINES-1:0] irq_in,
  input logic [IRQ_LINES-1:0] src_q,
  input logic [HALF_W-1:0]    mask_q,
  input logic [HALF_W-1:0]    vec,
  input logic                 irq_out,
  input logic                 bus_valid,
  input logic                 bus_write,
  input logic                 bus_rvalid,
  input logic                 mask_wr
);
  logic [2:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  generate
    if (SYNC_STAGES == 2) begin : g_lat
      a_r1_source_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd3) |-> (src_q == $past(irq_in, 3)));
    end
  endgenerate

  a_r2_irq_vs_vector: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (vec != '0));

  a_r4_vector_shape: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (vec[1:0] == 2'b00 && vec <= HALF_W'(IRQ_LINES * 4)));

  a_r3_rvalid_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> bus_rvalid);

  a_r3_rvalid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !bus_rvalid);

  a_r10_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_write) |=> $stable(mask_q));

  a_r10_write_needs_bus: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |-> (bus_valid && bus_write));

  a_r6_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3'd0) |-> (mask_q == MASK_RESET && src_q == '0 && !bus_rvalid));
endmodule

bind lvl_irq_ctrl lvl_irq_ctrl_chk #(.SYNC_STAGES(SYNC_STAGES), .MASK_RESET(MASK_RESET)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .src_q(src_q), .mask_q(mask_q),
  .vec(vec), .irq_out(irq_out), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_rvalid(bus_rvalid), .mask_wr(mask_wr)
);

// File: tb/lvl_irq_ctrl_bench.sv
module lvl_irq_ctrl_bench;
  localparam int AW = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_in = '0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [1:0]  bus_size = '0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        irq_out;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  lvl_irq_ctrl u_lvl_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_size(bus_size), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .irq_out(irq_out)
  );

  // Expected vector: scan upward, stop at first hit.
  function automatic logic [31:0] exp_vec(input logic [15:0] lines, input logic [15:0] m);
    logic [15:0] p;
    p = lines & m;
    for (int k = 0; k < 16; k++) if (p[k]) return 32'((k + 1) * 4);
    return 32'd0;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic bus_rd(input logic [1:0] sz, input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_size = sz; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    check("R3 rvalid", 32'(bus_rvalid), 32'd1);
    d = bus_rdata;
  endtask

  task automatic bus_wr(input logic [1:0] sz, input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_size = sz; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic set_lines(input logic [15:0] v);
    @(negedge clk);
    irq_in = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R6 irq_out", 32'(irq_out), 32'd0);
    check("R6 rvalid", 32'(bus_rvalid), 32'd0);
    bus_rd(2'd1, 12'h002, d); check("R6 mask reset", d, 32'h0010);
    bus_rd(2'd1, 12'h000, d); check("R6 vector idle", d, 32'h0);
    @(negedge clk); check("R3 rvalid low when idle", 32'(bus_rvalid), 32'd0);
  endtask

  task automatic t_latency();
    logic [31:0] d;
    @(negedge clk);
    irq_in = 16'h0010;
    @(negedge clk); @(negedge clk);
    check("R1 not yet after 2 edges", 32'(irq_out), 32'd0);
    @(negedge clk);
    check("R1 seen after 3 edges", 32'(irq_out), 32'd1);
    bus_rd(2'd1, 12'h000, d); check("R4 vector line 4", d, 32'h14);
    @(negedge clk);
    irq_in = 16'h0;
    @(negedge clk); @(negedge clk);
    check("R1 fall not yet", 32'(irq_out), 32'd1);
    @(negedge clk);
    check("R1 fall seen", 32'(irq_out), 32'd0);
  endtask

  task automatic t_mask_gate();
    logic [31:0] d;
    set_lines(16'h0300);
    check("R2 masked off", 32'(irq_out), 32'd0);
    bus_rd(2'd1, 12'h000, d); check("R4 masked vector", d, 32'h0);
    bus_wr(2'd1, 12'h002, 32'h0200);
    check("R2 enable at once", 32'(irq_out), 32'd1);
    bus_rd(2'd1, 12'h002, d); check("R5 mask readback", d, 32'h0200);
    bus_rd(2'd1, 12'h000, d); check("R4 vector line 9", d, exp_vec(16'h0300, 16'h0200));
    bus_wr(2'd1, 12'h002, 32'h0000);
    check("R2 disable at once", 32'(irq_out), 32'd0);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    set_lines(16'h8421);
    bus_wr(2'd1, 12'h002, 32'hFFFF);
    bus_rd(2'd1, 12'h000, d); check("R9 lowest line 0", d, 32'd4);
    bus_wr(2'd1, 12'h002, 32'hFFFE);
    bus_rd(2'd1, 12'h000, d); check("R9 next line 5", d, exp_vec(16'h8421, 16'hFFFE));
    bus_wr(2'd1, 12'h002, 32'h8000);
    bus_rd(2'd1, 12'h000, d); check("R9 top line 15", d, 32'd64);
  endtask

  task automatic t_bytes();
    logic [31:0] d;
    bus_wr(2'd1, 12'h002, 32'h1234);
    bus_wr(2'd0, 12'h003, 32'hFFFF_FFAB);
    bus_rd(2'd1, 12'h002, d); check("R7 high byte write", d, 32'hAB34);
    bus_wr(2'd0, 12'h002, 32'h0000_00CD);
    bus_rd(2'd1, 12'h002, d); check("R7 low byte write", d, 32'hABCD);
    bus_rd(2'd0, 12'h003, d); check("R7 byte read hi", d, 32'hAB);
    bus_rd(2'd0, 12'h002, d); check("R7 byte read lo", d, 32'hCD);
    bus_rd(2'd0, 12'h000, d); check("R7 vector low byte", d, exp_vec(16'h8421, 16'hABCD));
    bus_rd(2'd0, 12'h001, d); check("R7 vector high byte", d, 32'h0);
  endtask

  task automatic t_words();
    logic [31:0] d;
    bus_wr(2'd2, 12'h000, 32'h5A5A_00FF);
    bus_rd(2'd1, 12'h002, d); check("R8 word write upper half", d, 32'h5A5A);
    bus_rd(2'd2, 12'h000, d);
    check("R8 word read pair", d, {16'h5A5A, exp_vec(16'h8421, 16'h5A5A)[15:0]});
    bus_wr(2'd2, 12'h002, 32'hFFFF_0F0F);
    bus_rd(2'd2, 12'h002, d); check("R8 word lower half", d, 32'h0000_0F0F);
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    bus_wr(2'd1, 12'h000, 32'hFFFF);
    bus_wr(2'd1, 12'h004, 32'hFFFF);
    bus_wr(2'd1, 12'h003, 32'hFFFF);
    bus_wr(2'd3, 12'h002, 32'hFFFF_FFFF);
    bus_rd(2'd1, 12'h002, d); check("R10 stray writes ignored", d, 32'h0F0F);
    bus_rd(2'd1, 12'h004, d); check("R10 undecoded read", d, 32'h0);
    bus_rd(2'd1, 12'h100, d); check("R10 far offset read", d, 32'h0);
    bus_rd(2'd1, 12'h003, d); check("R10 odd halfword read", d, 32'h0);
    bus_rd(2'd3, 12'h002, d); check("R10 reserved size read", d, 32'h0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_mask_gate();
    t_priority();
    t_bytes();
    t_words();
    t_ignored();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule